// File: doc/BRIEF.md
# Radix-4 Zero-Skipping Fraction Multiplier

A sequential multiplier for signed two's-complement fractions with a base-4 exponent. A start pulse launches the product of an accumulator value (fraction and exponent) and an operand value. The accumulator fraction acts as the multiplier and is recoded into radix-4 digits from its least significant end. Each clock performs one step. A step adds 0, ±1 or ±2 times the operand to the upper half of a partial-product register. It then shifts the register right by two bits, or by four bits when the digit that follows is zero. Zero digits therefore cost no extra step.

When the loop finishes, the double-length product is brought back to base-4 normal form by a shift of two places, either right or left, or by no shift. The exponent sum is corrected to match. An exponent that is too large saturates and raises the overflow flag. An exponent that is too small flushes the result to zero at the minimum exponent. All inputs must stay steady from start until done. The fraction width `FRAC_W` must be at least 5. The result has `2*FRAC_W-1` bits: a sign bit and `2*FRAC_W-2` fraction bits.

Top module: `frac_mul_r4`

## Requirements
- R1: With A and M the two fraction inputs read as signed integers, the raw double-length product is exactly A·M. The fraction point of `prod_frac` lies just below its sign bit.
- R2: Each step adds d·operand to the upper part. The digit d ∈ {0,+1,−1,+2,−2} equals −2·b1 + b0 + c, where b1,b0 are the two lowest unconsumed multiplier bits and c is the bit below them. The bit c is zero at start.
- R3: A step consumes two digits (a 4-bit shift) when at least two digits remain and the next digit is zero, that is, when multiplier bits 3..1 are all equal. Otherwise the step consumes one digit (a 2-bit shift).
- R4: The digit counter starts at ceil(FRAC_W/2), and the loop ends when it reaches zero. If S steps are taken, done is high after the (S+2)-th rising edge, counting the edge that samples start as the first.
- R5: A raw product of exactly +1 (both inputs −1) is shifted right two places, and the exponent becomes the exponent sum plus 1.
- R6: A raw product that is zero, or whose top three bits (in the `2*FRAC_W-1`-bit result format) are not all equal, is kept unshifted. The exponent is the exponent sum.
- R7: Any other raw product is shifted left two places, and the exponent becomes the exponent sum minus 1.
- R8: If the corrected exponent exceeds 2^(EXP_W−1)−1, `ovf` is 1 and `prod_exp` is held at that maximum. The fraction keeps its normalized value.
- R9: If the corrected exponent is below −2^(EXP_W−1), the fraction becomes 0, `prod_exp` becomes −2^(EXP_W−1) and `ovf` is 0.
- R10: `done` is high for exactly one cycle per operation. `prod_frac`, `prod_exp` and `ovf` keep their values until the next done.
- R11: After reset, `done`, `ovf`, `prod_frac` and `prod_exp` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins an operation when the block is idle |
| acc_frac | input | FRAC_W | Accumulator fraction (multiplier), two's complement |
| acc_exp | input | EXP_W | Accumulator exponent, two's complement, base 4 |
| opnd_frac | input | FRAC_W | Operand fraction (multiplicand), two's complement |
| opnd_exp | input | EXP_W | Operand exponent, two's complement, base 4 |
| done | output | 1 | One-cycle completion pulse |
| prod_frac | output | 2*FRAC_W-1 | Normalized double-length product fraction |
| prod_exp | output | EXP_W | Result exponent |
| ovf | output | 1 | Exponent overflow flag |

## Verification
The bench builds the block with `FRAC_W = 7` and `EXP_W = 4`. With these widths, every one of the 16384 fraction pairs can be multiplied with both exponents at zero. That sweep covers every recoding pattern, every run of zero digits that triggers a four-bit step, the single +1 product and both shift directions, and it checks the exact step count of each operation. A four-bit exponent has a range of only −8..7. A sweep over all 256 exponent pairs, each combined with fraction pairs that select each normalization case and a zero product, therefore reaches saturation and flush-to-zero on both sides of every boundary.

// File: rtl/frac_mul_r4_pkg.sv
package frac_mul_r4_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_FIN  = 2'd2
    } mul_state_e;

    typedef enum logic [1:0] {
        NRM_KEEP   = 2'd0,
        NRM_RIGHT2 = 2'd1,
        NRM_LEFT2  = 2'd2
    } nrm_case_e;

    typedef logic signed [2:0] bdigit_t;

    typedef struct packed {
        bdigit_t digit;   // signed multiple of the operand for this step
        logic    quad;    // step also consumes the following zero digit
    } step_ctl_t;

    // radix-4 recoding of a bit pair plus the bit beneath it
    function automatic bdigit_t booth_digit(input logic hi, input logic lo, input logic below);
        bdigit_t v;
        unique case ({hi, lo, below})
            3'b000, 3'b111: v = 3'sd0;
            3'b001, 3'b010: v = 3'sd1;
            3'b011:         v = 3'sd2;
            3'b100:         v = -3'sd2;
            default:        v = -3'sd1;
        endcase
        return v;
    endfunction

    function automatic logic trio_equal(input logic [2:0] t);
        return (t == 3'b000) || (t == 3'b111);
    endfunction
endpackage

// File: rtl/frac_mul_r4_recode.sv
module frac_mul_r4_recode
    import frac_mul_r4_pkg::*;
(
    input  logic [3:0] q_low,
    input  logic       carry,
    input  logic       two_left,
    output step_ctl_t  ctl
);
    timeunit 1ns;
    timeprecision 1ps;

    always_comb begin
        ctl.digit = booth_digit(q_low[1], q_low[0], carry);
        // next digit is zero exactly when bits 3..1 agree
        ctl.quad  = two_left && trio_equal(q_low[3:1]);
    end
endmodule

// File: rtl/frac_mul_r4_core.sv
module frac_mul_r4_core
    import frac_mul_r4_pkg::*;
#(
    parameter int FW = 45
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            step_en,
    input  logic [FW-1:0]   a_frac,
    input  logic [FW-1:0]   m_frac,
    output logic            last_step,
    output logic [2*FW-1:0] prod2
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N   = (FW + 1) / 2;
    localparam int QW  = 2 * N;
    localparam int HW  = FW + 3;
    localparam int PPW = HW + QW;
    localparam int CW  = $clog2(N + 1);

    logic signed [PPW-1:0] pp;
    logic [QW-1:0]         q;
    logic                  carry;
    logic [CW-1:0]         cnt;
    logic [QW-1:0]         q_init;
    step_ctl_t             ctl;

    logic signed [HW-1:0]  m_ext;
    logic signed [HW-1:0]  mult;
    logic signed [HW-1:0]  hi_sum;
    logic signed [PPW-1:0] joined;
    logic signed [PPW-1:0] shifted;

    frac_mul_r4_recode u_rec (
        .q_low   (q[3:0]),
        .carry   (carry),
        .two_left(cnt >= CW'(2)),
        .ctl     (ctl)
    );

    generate
        if (QW > FW) begin : g_pad
            assign q_init = {{(QW-FW){a_frac[FW-1]}}, a_frac};
        end else begin : g_fit
            assign q_init = a_frac;
        end
    endgenerate

    assign m_ext = HW'($signed(m_frac));

    always_comb begin
        unique case (ctl.digit)
            3'sd1:   mult = m_ext;
            -3'sd1:  mult = -m_ext;
            3'sd2:   mult = m_ext <<< 1;
            -3'sd2:  mult = -(m_ext <<< 1);
            default: mult = '0;
        endcase
        hi_sum  = $signed(pp[PPW-1 -: HW]) + mult;
        joined  = $signed({hi_sum, pp[QW-1:0]});
        shifted = ctl.quad ? (joined >>> 4) : (joined >>> 2);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pp    <= '0;
            q     <= '0;
            carry <= 1'b0;
            cnt   <= '0;
        end else if (load) begin
            pp    <= '0;
            q     <= q_init;
            carry <= 1'b0;
            cnt   <= CW'(N);
        end else if (step_en) begin
            pp    <= shifted;
            q     <= ctl.quad ? {{4{q[QW-1]}}, q[QW-1:4]} : {{2{q[QW-1]}}, q[QW-1:2]};
            carry <= ctl.quad ? q[3] : q[1];
            cnt   <= cnt - (ctl.quad ? CW'(2) : CW'(1));
        end
    end

    assign last_step = (cnt == (ctl.quad ? CW'(2) : CW'(1)));
    assign prod2     = pp[2*FW-1:0];

    AST_LOAD_INIT: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == CW'(N)) && !carry && (pp == '0)); // R2
    AST_STEP_LIVE: assert property (@(posedge clk) disable iff (rst)
        step_en |-> (cnt != '0)); // R4
    AST_CNT_DROP: assert property (@(posedge clk) disable iff (rst)
        step_en |=> (cnt == $past(cnt) - CW'(1)) || (cnt == $past(cnt) - CW'(2))); // R3
    AST_TAIL_PAIR: assert property (@(posedge clk) disable iff (rst)
        (step_en && cnt == CW'(1)) |=> (cnt == '0)); // R4
endmodule

// File: rtl/frac_mul_r4_norm.sv
module frac_mul_r4_norm
    import frac_mul_r4_pkg::*;
#(
    parameter int FW = 45,
    parameter int EW = 8
) (
    input  logic [2*FW-1:0] prod2,
    input  logic [EW-1:0]   ea,
    input  logic [EW-1:0]   em,
    output logic [2*FW-2:0] frac_o,
    output logic [EW-1:0]   exp_o,
    output logic            ovf_o,
    output logic            unf_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PW     = 2 * FW - 1;
    localparam int SW     = EW + 2;
    localparam int EMAX_I = (1 << (EW - 1)) - 1;
    localparam int EMIN_I = -(1 << (EW - 1));

    nrm_case_e             ncase;
    logic                  plus_one;
    logic                  keep;
    logic [PW-1:0]         frac_n;
    logic signed [SW-1:0]  adj;
    logic signed [SW-1:0]  esum;
    logic signed [SW-1:0]  eadj;

    always_comb begin
        plus_one = (prod2[2*FW-1:2*FW-2] == 2'b01);
        keep     = (prod2 == '0) || !trio_equal(prod2[2*FW-2 -: 3]);
        if (plus_one)  ncase = NRM_RIGHT2;
        else if (keep) ncase = NRM_KEEP;
        else           ncase = NRM_LEFT2;

        unique case (ncase)
            NRM_RIGHT2: begin
                frac_n = {prod2[2*FW-1], prod2[2*FW-1:2]};
                adj    = SW'(1);
            end
            NRM_LEFT2: begin
                frac_n = {prod2[PW-3:0], 2'b00};
                adj    = -SW'(1);
            end
            default: begin
                frac_n = prod2[PW-1:0];
                adj    = '0;
            end
        endcase

        esum  = SW'($signed(ea)) + SW'($signed(em));
        eadj  = esum + adj;
        ovf_o = 1'b0;
        unf_o = 1'b0;
        frac_o = frac_n;
        exp_o  = eadj[EW-1:0];
        if (eadj > SW'(EMAX_I)) begin
            ovf_o = 1'b1;
            exp_o = EW'(EMAX_I);
        end else if (eadj < SW'(EMIN_I)) begin
            unf_o  = 1'b1;
            frac_o = '0;
            exp_o  = EW'(EMIN_I);
        end
    end
endmodule

// File: rtl/frac_mul_r4.sv
module frac_mul_r4
    import frac_mul_r4_pkg::*;
#(
    parameter int FRAC_W = 45,
    parameter int EXP_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [FRAC_W-1:0]     acc_frac,
    input  logic [EXP_W-1:0]      acc_exp,
    input  logic [FRAC_W-1:0]     opnd_frac,
    input  logic [EXP_W-1:0]      opnd_exp,
    output logic                  done,
    output logic [2*FRAC_W-2:0]   prod_frac,
    output logic [EXP_W-1:0]      prod_exp,
    output logic                  ovf
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [EXP_W-1:0] EXP_MAX = {1'b0, {(EXP_W-1){1'b1}}};
    localparam logic [EXP_W-1:0] EXP_MIN = {1'b1, {(EXP_W-1){1'b0}}};

    mul_state_e              state;
    logic                    load;
    logic                    step_en;
    logic                    last_step;
    logic [2*FRAC_W-1:0]     prod2;
    logic [2*FRAC_W-2:0]     n_frac;
    logic [EXP_W-1:0]        n_exp;
    logic                    n_ovf;
    logic                    n_unf;

    assign load    = (state == ST_IDLE) && start;
    assign step_en = (state == ST_STEP);

    frac_mul_r4_core #(.FW(FRAC_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .step_en  (step_en),
        .a_frac   (acc_frac),
        .m_frac   (opnd_frac),
        .last_step(last_step),
        .prod2    (prod2)
    );

    frac_mul_r4_norm #(.FW(FRAC_W), .EW(EXP_W)) u_norm (
        .prod2 (prod2),
        .ea    (acc_exp),
        .em    (opnd_exp),
        .frac_o(n_frac),
        .exp_o (n_exp),
        .ovf_o (n_ovf),
        .unf_o (n_unf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            done      <= 1'b0;
            prod_frac <= '0;
            prod_exp  <= '0;
            ovf       <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) state <= ST_STEP;
                ST_STEP: if (last_step) state <= ST_FIN;
                ST_FIN: begin
                    prod_frac <= n_frac;
                    prod_exp  <= n_exp;
                    ovf       <= n_ovf;
                    done      <= 1'b1;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state != ST_FIN) |=> $stable(prod_frac) && $stable(prod_exp) && $stable(ovf)); // R10
    AST_OVF_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (done && ovf) |-> (prod_exp == EXP_MAX)); // R8
    AST_UNF_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FIN && n_unf) |=> (prod_frac == '0) && (prod_exp == EXP_MIN) && !ovf); // R9
    AST_FIN_ORDER: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FIN) |-> ($past(state) == ST_STEP)); // R4
endmodule

// File: tb/frac_mul_r4_bench.sv
module frac_mul_r4_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int FW  = 7;
    localparam int EW  = 4;
    localparam int PW  = 2 * FW - 1;
    localparam int ND  = (FW + 1) / 2;
    localparam int BQW = 2 * ND;
    localparam int ONE = 1 << (2 * FW - 2);   // raw +1
    localparam int THR = 1 << (2 * FW - 4);   // base-4 normal threshold
    localparam int EMX = (1 << (EW - 1)) - 1;
    localparam int EMN = -(1 << (EW - 1));

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [FW-1:0] acc_frac = '0;
    logic [EW-1:0] acc_exp = '0;
    logic [FW-1:0] opnd_frac = '0;
    logic [EW-1:0] opnd_exp = '0;
    logic          done;
    logic [PW-1:0] prod_frac;
    logic [EW-1:0] prod_exp;
    logic          ovf;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    frac_mul_r4 #(.FRAC_W(FW), .EXP_W(EW)) u_frac_mul_r4 (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .acc_frac (acc_frac),
        .acc_exp  (acc_exp),
        .opnd_frac(opnd_frac),
        .opnd_exp (opnd_exp),
        .done     (done),
        .prod_frac(prod_frac),
        .prod_exp (prod_exp),
        .ovf      (ovf)
    );

    // radix-4 digit i of the multiplier, from the rule in R2
    function automatic int digit_of(input logic [BQW-1:0] b, input int i);
        int below;
        below = (i == 0) ? 0 : int'(b[2*i-1]);
        return -2 * int'(b[2*i+1]) + int'(b[2*i]) + below;
    endfunction

    // step count from the skip rule in R3
    function automatic int steps_for(input int a);
        logic [BQW-1:0] b;
        int i;
        int s;
        b = BQW'(a);
        i = 0;
        s = 0;
        while (i < ND) begin
            s++;
            if (i + 1 < ND && digit_of(b, i + 1) == 0) i += 2;
            else i += 1;
        end
        return s;
    endfunction

    task automatic run_op(input int a, input int ea, input int m, input int em);
        int p, ef, ee, adj, lat;
        bit eo;
        string tag;
        logic [PW-1:0] hold_f;
        logic [EW-1:0] hold_e;
        logic hold_o;
        p = a * m;
        if (p == ONE) begin
            ef = p / 4; adj = 1; tag = "R5";
        end else if (p == 0 || p >= THR || p < -THR) begin
            ef = p; adj = 0; tag = "R6";
        end else begin
            ef = p * 4; adj = -1; tag = "R7";
        end
        ee = ea + em + adj;
        eo = 1'b0;
        if (ee > EMX) begin
            eo = 1'b1; ee = EMX; tag = {tag, "/R8"};
        end else if (ee < EMN) begin
            ef = 0; ee = EMN; tag = {tag, "/R9"};
        end

        @(negedge clk);
        acc_frac  = FW'(a);
        opnd_frac = FW'(m);
        acc_exp   = EW'(ea);
        opnd_exp  = EW'(em);
        start     = 1'b1;
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        start = 1'b0;
        while (!done && lat < 40) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end

        n_chk++;
        if ($signed(prod_frac) != ef || $signed(prod_exp) != ee || ovf != eo) begin
            n_bad++;
            $display("FAIL R1/R2/%s a=%0d m=%0d ea=%0d em=%0d: got frac=%0d exp=%0d ovf=%0b, expected frac=%0d exp=%0d ovf=%0b",
                     tag, a, m, ea, em, $signed(prod_frac), $signed(prod_exp), ovf, ef, ee, eo);
        end
        n_chk++;
        if (lat != steps_for(a) + 2) begin
            n_bad++;
            $display("FAIL R3/R4 latency a=%0d: got %0d, expected %0d", a, lat, steps_for(a) + 2);
        end

        hold_f = prod_frac;
        hold_e = prod_exp;
        hold_o = ovf;
        @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (done || prod_frac != hold_f || prod_exp != hold_e || ovf != hold_o) begin
            n_bad++;
            $display("FAIL R10 after pulse: got done=%0b frac=%0d, expected done=0 frac=%0d",
                     done, $signed(prod_frac), $signed(hold_f));
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R10 watchdog: got no finish, expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_chk++;
        if (done || ovf || prod_frac != '0 || prod_exp != '0) begin
            n_bad++;
            $display("FAIL R11 reset: got done=%0b ovf=%0b frac=%0d exp=%0d, expected all 0",
                     done, ovf, prod_frac, prod_exp);
        end

        // R1 R2 R3 R5 R6 R7: all fraction pairs, zero exponents
        for (int a = -(1 << (FW - 1)); a < (1 << (FW - 1)); a++) begin
            for (int m = -(1 << (FW - 1)); m < (1 << (FW - 1)); m++) begin
                run_op(a, 0, m, 0);
            end
        end

        // R8 R9: all exponent pairs against each normalization case and a zero product
        for (int ea = EMN; ea <= EMX; ea++) begin
            for (int em = EMN; em <= EMX; em++) begin
                run_op(-64, ea, -64, em);
                run_op(32, ea, 32, em);
                run_op(32, ea, 16, em);
                run_op(0, ea, 32, em);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule